// File: doc/BRIEF.md
# Channel Output Signature Analyzer

This block checks that a filter channel is working by folding its output samples into a short signature. The I and Q output streams each go into their own 16-bit multiple-input signature register. Software clears both signatures, programs how many valid output samples to observe, and arms the run with a one-shot start pulse. A short hold-off delay follows the pulse. Once the programmed number of samples has been folded in, the signatures freeze and a done flag rises. Software then compares the two signatures with values taken from a known-good channel that used the same setup. If they match, a fault in the channel is very unlikely.

The block also chooses the stimulus that feeds the channel under test. The source can be external test vectors, a free-running 23-bit pseudonoise sequence, or a constant most-negative input. With the constant input, the downstream mixer produces a sine at its tuned frequency. The stimulus goes out through one register stage. The filter datapath sits outside this block, between the stimulus outputs and the sample inputs.

Top module: `chan_sig_analyzer`

## Requirements
- R1: A clock edge with `rst_n` low makes both signatures 0, `done` 0, both stimulus outputs 0, and the pseudonoise register 23'h000001.
- R2: When `src_sel[1]`=1, the stimulus comes from the pseudonoise register P. P shifts left on every clock, and its new bit 0 is P[22]^P[17]. The edge loads `stim_i`=P[15:0] and `stim_q`=P[22:7], taking P as it stood before that edge.
- R3: When `src_sel`=2'b00, the edge loads `stim_i` and `stim_q` with `ext_i` and `ext_q`, so the outputs follow the inputs with one cycle of delay.
- R4: When `src_sel`=2'b01, the edge loads both stimulus outputs with 16'h8000, the most negative value.
- R5: While compaction is running, each edge with `flt_valid`=1 updates the I signature S to (S<<1) ^ (S[15] ? 16'h1021 : 0) ^ `flt_i`. S changes on no other edge, except when it is cleared.
- R6: The Q signature follows the same rule with `flt_q`, independently of I.
- R7: A `start_sync` pulse seen while idle, with `obs_count`≠0, starts a hold-off. Compaction begins `holdoff` edges after the pulse edge, with 0 counted as 1. A valid sample during the hold-off is not folded in.
- R8: The edge that folds in the `obs_count`-th valid sample also sets `done`. After that, both signatures and `done` hold until they are cleared.
- R9: `sig_clr`=1 on an edge sets both signatures to 0, clears `done` and returns the block to idle. It wins over every other input.
- R10: `start_sync` has no effect when `obs_count`=0, during a hold-off, during compaction, or after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_sel | input | 2 | Stimulus select: bit1 picks pseudonoise, else bit0 picks the constant, else external |
| ext_i | input | 16 | External I test vector |
| ext_q | input | 16 | External Q test vector |
| stim_i | output | 16 | Registered I stimulus to the channel |
| stim_q | output | 16 | Registered Q stimulus to the channel |
| flt_valid | input | 1 | Filter output sample valid |
| flt_i | input | 16 | Filter I output sample |
| flt_q | input | 16 | Filter Q output sample |
| start_sync | input | 1 | One-shot start pulse |
| obs_count | input | 20 | Number of valid samples to observe; 0 disables the test |
| holdoff | input | 8 | Start hold-off in clock edges |
| sig_clr | input | 1 | Clear both signatures and `done` |
| sig_i | output | 16 | I signature |
| sig_q | output | 16 | Q signature |
| done | output | 1 | Observation finished |

## Verification
Every result is due on the first clock edge after the inputs that cause it. The stimulus outputs, each signature step, `done` and a clear all appear one edge after they are driven. Compaction starts `holdoff` edges after the edge that sees the start pulse. The bench drives inputs just after a falling edge and steps its own behavioural model for the rising edge that follows. It then compares every output with that model at the next falling edge, so each comparison sees the design exactly one register stage after its stimulus. Directed sequences put samples inside the hold-off window, past the programmed count, and alongside clears and repeated start pulses.

// File: rtl/sig_pkg.sv
// Package: types shared by the channel signature analyzer.
// Assumes: the block has exactly two lanes, I and Q.
package sig_pkg;
    localparam int LANES = 2;

    typedef enum logic [1:0] {
        OBS_IDLE = 2'd0,
        OBS_WAIT = 2'd1,
        OBS_RUN  = 2'd2,
        OBS_DONE = 2'd3
    } obs_state_e;
endpackage

// File: rtl/sig_pn_gen.sv
// Module: free-running Fibonacci LFSR, the pseudonoise stimulus source.
// Assumes: the tap pair gives a maximal-length sequence, and SEED is nonzero.
module sig_pn_gen #(
    parameter int PN_W  = 23,
    parameter int TAP_A = 23,
    parameter int TAP_B = 18,
    parameter logic [PN_W-1:0] SEED = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PN_W-1:0] pn
);
    logic feedback;

    // Purpose: XOR the two taps to form the new bit.
    always_comb begin
        feedback = pn[TAP_A-1] ^ pn[TAP_B-1];
    end

    // Purpose: shift every clock; reset loads the seed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pn <= SEED;
        end else begin
            pn <= {pn[PN_W-2:0], feedback};
        end
    end
endmodule

// File: rtl/sig_stim_mux.sv
// Module: picks the channel test stimulus and registers it.
// Assumes: PN_W >= DATA_W. Pseudonoise wins over the constant.
module sig_stim_mux #(
    parameter int DATA_W = 16,
    parameter int PN_W   = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        src_sel,
    input  logic [DATA_W-1:0] ext_i,
    input  logic [DATA_W-1:0] ext_q,
    input  logic [PN_W-1:0]   pn,
    output logic [DATA_W-1:0] stim_i,
    output logic [DATA_W-1:0] stim_q
);
    localparam logic [DATA_W-1:0] NEG_FS = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] nxt_i;
    logic [DATA_W-1:0] nxt_q;

    // Purpose: choose the source by priority.
    always_comb begin
        if (src_sel[1]) begin
            nxt_i = pn[DATA_W-1:0];
            nxt_q = pn[PN_W-1 -: DATA_W];
        end else if (src_sel[0]) begin
            nxt_i = NEG_FS;
            nxt_q = NEG_FS;
        end else begin
            nxt_i = ext_i;
            nxt_q = ext_q;
        end
    end

    // Purpose: register the chosen stimulus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stim_i <= '0;
            stim_q <= '0;
        end else begin
            stim_i <= nxt_i;
            stim_q <= nxt_q;
        end
    end
endmodule

// File: rtl/sig_misr.sv
// Module: one multiple-input signature register lane.
// Assumes: POLY holds the feedback terms below the top degree. Data wider
// than the register is folded in by XOR.
module sig_misr #(
    parameter int SIG_W  = 16,
    parameter int DATA_W = 16,
    parameter logic [SIG_W-1:0] POLY = 16'h1021
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [DATA_W-1:0] din,
    output logic [SIG_W-1:0]  sig
);
    logic [SIG_W-1:0] din_w;
    logic [SIG_W-1:0] sig_nxt;

    // Purpose: fold the sample onto the register width.
    always_comb begin
        din_w = '0;
        for (int b = 0; b < DATA_W; b++) begin
            din_w[b % SIG_W] = din_w[b % SIG_W] ^ din[b];
        end
    end

    // Purpose: one shift with feedback, plus the sample.
    always_comb begin
        sig_nxt = {sig[SIG_W-2:0], 1'b0} ^ (sig[SIG_W-1] ? POLY : '0) ^ din_w;
    end

    // Purpose: hold the signature; a clear wins over an update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig <= '0;
        end else if (clr) begin
            sig <= '0;
        end else if (en) begin
            sig <= sig_nxt;
        end
    end
endmodule

// File: rtl/sig_obs_ctrl.sv
// Module: arm, hold-off and sample counting for the signature run.
// Assumes: obs_count and holdoff stay stable during a run. A holdoff of 0
// behaves like 1.
module sig_obs_ctrl
    import sig_pkg::*;
#(
    parameter int CNT_W  = 20,
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              start_sync,
    input  logic              valid,
    input  logic [CNT_W-1:0]  obs_count,
    input  logic [HOLD_W-1:0] holdoff,
    output logic              compact_en,
    output logic              done
);
    obs_state_e        state;
    logic [CNT_W-1:0]  seen;
    logic [HOLD_W-1:0] hold;
    logic              last_sample;

    // Purpose: decode the enable, the final sample and the done flag.
    always_comb begin
        compact_en  = (state == OBS_RUN) && valid && !clr;
        last_sample = (seen + 1'b1) == obs_count;
        done        = (state == OBS_DONE);
    end

    // Purpose: state, hold-off countdown and sample counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state <= OBS_IDLE;
            seen  <= '0;
            hold  <= '0;
        end else begin
            case (state)
                OBS_IDLE: begin
                    if (start_sync && (obs_count != '0)) begin
                        state <= OBS_WAIT;
                        hold  <= holdoff;
                        seen  <= '0;
                    end
                end
                OBS_WAIT: begin
                    if (hold <= HOLD_W'(1)) begin
                        state <= OBS_RUN;
                    end else begin
                        hold <= hold - 1'b1;
                    end
                end
                OBS_RUN: begin
                    if (valid) begin
                        seen <= seen + 1'b1;
                        if (last_sample) begin
                            state <= OBS_DONE;
                        end
                    end
                end
                default: begin
                    state <= OBS_DONE;
                end
            endcase
        end
    end
endmodule

// File: rtl/chan_sig_analyzer.sv
// Module: top of the channel signature analyzer. It holds the stimulus source
// and the I/Q signature compaction.
// Assumes: flt_* come from the channel's filter output, and stim_* drive its input.
module chan_sig_analyzer
    import sig_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int SIG_W    = 16,
    parameter logic [SIG_W-1:0] SIG_POLY = 16'h1021,
    parameter int CNT_W    = 20,
    parameter int HOLD_W   = 8,
    parameter int PN_W     = 23,
    parameter int PN_TAP   = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        src_sel,
    input  logic [DATA_W-1:0] ext_i,
    input  logic [DATA_W-1:0] ext_q,
    output logic [DATA_W-1:0] stim_i,
    output logic [DATA_W-1:0] stim_q,
    input  logic              flt_valid,
    input  logic [DATA_W-1:0] flt_i,
    input  logic [DATA_W-1:0] flt_q,
    input  logic              start_sync,
    input  logic [CNT_W-1:0]  obs_count,
    input  logic [HOLD_W-1:0] holdoff,
    input  logic              sig_clr,
    output logic [SIG_W-1:0]  sig_i,
    output logic [SIG_W-1:0]  sig_q,
    output logic              done
);
    logic [PN_W-1:0]   pn;
    logic              compact_en;
    logic [DATA_W-1:0] lane_d [LANES];
    logic [SIG_W-1:0]  lane_s [LANES];

    sig_pn_gen #(
        .PN_W  (PN_W),
        .TAP_A (PN_W),
        .TAP_B (PN_TAP),
        .SEED  (PN_W'(1))
    ) u_pn (
        .clk   (clk),
        .rst_n (rst_n),
        .pn    (pn)
    );

    sig_stim_mux #(
        .DATA_W (DATA_W),
        .PN_W   (PN_W)
    ) u_stim (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_sel (src_sel),
        .ext_i   (ext_i),
        .ext_q   (ext_q),
        .pn      (pn),
        .stim_i  (stim_i),
        .stim_q  (stim_q)
    );

    sig_obs_ctrl #(
        .CNT_W  (CNT_W),
        .HOLD_W (HOLD_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (sig_clr),
        .start_sync (start_sync),
        .valid      (flt_valid),
        .obs_count  (obs_count),
        .holdoff    (holdoff),
        .compact_en (compact_en),
        .done       (done)
    );

    // Purpose: put the I and Q samples onto the lane array.
    always_comb begin
        lane_d[0] = flt_i;
        lane_d[1] = flt_q;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sig_misr #(
            .SIG_W  (SIG_W),
            .DATA_W (DATA_W),
            .POLY   (SIG_POLY)
        ) u_misr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (sig_clr),
            .en    (compact_en),
            .din   (lane_d[g]),
            .sig   (lane_s[g])
        );
    end

    // Purpose: bring the lane signatures out to the ports.
    always_comb begin
        sig_i = lane_s[0];
        sig_q = lane_s[1];
    end
endmodule

// File: rtl/chan_sig_analyzer_chk.sv
// Module: assertion checker bound to chan_sig_analyzer.
// Assumes: it sees only the ports of the top module.
module chan_sig_analyzer_chk #(
    parameter int DATA_W = 16,
    parameter int SIG_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        src_sel,
    input logic [DATA_W-1:0] ext_i,
    input logic [DATA_W-1:0] ext_q,
    input logic [DATA_W-1:0] stim_i,
    input logic [DATA_W-1:0] stim_q,
    input logic              flt_valid,
    input logic              sig_clr,
    input logic [SIG_W-1:0]  sig_i,
    input logic [SIG_W-1:0]  sig_q,
    input logic              done
);
    localparam logic [DATA_W-1:0] NEG_FS = {1'b1, {(DATA_W-1){1'b0}}};

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (sig_i == '0 && sig_q == '0 && !done && stim_i == '0 && stim_q == '0));

    a_r3_ext_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'b00) |=> (stim_i == $past(ext_i) && stim_q == $past(ext_q)));

    a_r4_neg_full_scale: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'b01) |=> (stim_i == NEG_FS && stim_q == NEG_FS));

    a_r5_no_valid_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!flt_valid && !sig_clr) |=> ($stable(sig_i) && $stable(sig_q)));

    a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !sig_clr) |=> (done && $stable(sig_i) && $stable(sig_q)));

    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        sig_clr |=> (sig_i == '0 && sig_q == '0 && !done));
endmodule

bind chan_sig_analyzer chan_sig_analyzer_chk #(
    .DATA_W (DATA_W),
    .SIG_W  (SIG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_sel   (src_sel),
    .ext_i     (ext_i),
    .ext_q     (ext_q),
    .stim_i    (stim_i),
    .stim_q    (stim_q),
    .flt_valid (flt_valid),
    .sig_clr   (sig_clr),
    .sig_i     (sig_i),
    .sig_q     (sig_q),
    .done      (done)
);

// File: tb/tb_chan_sig_analyzer.sv
// Bench: a behavioural reference model, compared with the design after every edge.
module tb_chan_sig_analyzer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  src_sel = 2'b00;
    logic [15:0] ext_i = '0, ext_q = '0;
    logic [15:0] stim_i, stim_q;
    logic        flt_valid = 1'b0;
    logic [15:0] flt_i = '0, flt_q = '0;
    logic        start_sync = 1'b0;
    logic [19:0] obs_count = '0;
    logic [7:0]  holdoff = 8'd1;
    logic        sig_clr = 1'b0;
    logic [15:0] sig_i, sig_q;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // model state
    logic [22:0] m_pn;
    logic [15:0] m_si, m_sq, m_sig_i, m_sig_q;
    bit          m_done;
    int          m_phase;   // 0 idle, 1 hold-off, 2 running, 3 finished
    int          m_hold, m_seen;

    always #10 clk = ~clk;

    chan_sig_analyzer dut (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .ext_i(ext_i), .ext_q(ext_q),
        .stim_i(stim_i), .stim_q(stim_q), .flt_valid(flt_valid), .flt_i(flt_i),
        .flt_q(flt_q), .start_sync(start_sync), .obs_count(obs_count),
        .holdoff(holdoff), .sig_clr(sig_clr), .sig_i(sig_i), .sig_q(sig_q), .done(done)
    );

    function automatic logic [15:0] sig_step(logic [15:0] s, logic [15:0] d);
        logic [15:0] t;
        t = s << 1;
        if (s[15]) t = t ^ 16'h1021;
        return t ^ d;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // one rising edge of the model, using the inputs that are held across it
    task automatic model_edge();
        logic [22:0] p;
        if (!rst_n) begin
            m_pn = 23'd1; m_si = 0; m_sq = 0; m_sig_i = 0; m_sig_q = 0;
            m_done = 0; m_phase = 0; m_hold = 0; m_seen = 0;
            return;
        end
        p = m_pn;
        if (src_sel[1]) begin m_si = p[15:0]; m_sq = p[22:7]; end
        else if (src_sel[0]) begin m_si = 16'h8000; m_sq = 16'h8000; end
        else begin m_si = ext_i; m_sq = ext_q; end
        m_pn = {p[21:0], p[22] ^ p[17]};
        if (sig_clr) begin
            m_sig_i = 0; m_sig_q = 0; m_done = 0; m_phase = 0; m_seen = 0;
        end else if (m_phase == 0) begin
            if (start_sync && obs_count != 0) begin m_phase = 1; m_hold = holdoff; end
        end else if (m_phase == 1) begin
            if (m_hold <= 1) m_phase = 2; else m_hold--;
        end else if (m_phase == 2) begin
            if (flt_valid) begin
                m_sig_i = sig_step(m_sig_i, flt_i);
                m_sig_q = sig_step(m_sig_q, flt_q);
                m_seen++;
                if (m_seen == obs_count) begin m_phase = 3; m_done = 1; end
            end
        end
    endtask

    // advance one clock, then compare every output with the model
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        model_edge();
        check(src_sel[1] ? "R2 stim_i" : (src_sel[0] ? "R4 stim_i" : "R3 stim_i"), stim_i, m_si);
        check(src_sel[1] ? "R2 stim_q" : (src_sel[0] ? "R4 stim_q" : "R3 stim_q"), stim_q, m_sq);
        check("R5 sig_i", sig_i, m_sig_i);
        check("R6 sig_q", sig_q, m_sig_q);
        check("R8 done", done, m_done);
    endtask

    task automatic run(int n);
        for (int k = 0; k < n; k++) begin
            flt_valid = $urandom_range(0, 2) != 0;
            flt_i = 16'($urandom); flt_q = 16'($urandom);
            ext_i = 16'($urandom); ext_q = 16'($urandom);
            tick();
        end
        flt_valid = 0;
    endtask

    task automatic pulse_sync();
        start_sync = 1; tick(); start_sync = 0;
    endtask

    task automatic clear();
        sig_clr = 1; tick(); sig_clr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        rst_n = 0; tick(); tick();
        check("R1 sig_i", sig_i, 0); check("R1 sig_q", sig_q, 0);
        check("R1 done", done, 0); check("R1 stim_i", stim_i, 0);
        rst_n = 1;
        // R3: external vectors
        src_sel = 2'b00; run(8);
        // R4: constant input
        src_sel = 2'b01; run(5);
        // R2: pseudonoise, including select 11
        src_sel = 2'b10; run(30);
        src_sel = 2'b11; run(10);
        src_sel = 2'b00;
        // R5, R6: a known first step from zero
        clear();
        obs_count = 20'd1; holdoff = 8'd1;
        pulse_sync();                    // hold-off edge
        flt_valid = 1; flt_i = 16'h0001; flt_q = 16'h8000; tick();
        flt_valid = 1; flt_i = 16'h0001; tick();   // sample is folded at this edge
        flt_valid = 0;
        check("R5 single sample", sig_i, 16'h0001);
        check("R6 single sample", sig_q, 16'h8000);
        check("R8 done after one", done, 1);
        run(6);                          // R8: hold after done
        check("R8 hold", sig_i, 16'h0001);
        // R7: a longer hold-off with valid samples inside it
        clear();
        obs_count = 20'd5; holdoff = 8'd4;
        flt_valid = 1; start_sync = 1; tick(); start_sync = 0;
        tick(); tick();
        check("R7 no compaction in hold-off", sig_i, 0);
        run(20);
        check("R8 done reached", done, 1);
        // R10: sync while running and while finished; count zero
        clear();
        obs_count = 20'd12; holdoff = 8'd0;
        pulse_sync(); run(3); pulse_sync(); run(30);
        pulse_sync(); run(3);
        clear();
        obs_count = 20'd0; pulse_sync();
        flt_valid = 1; flt_i = 16'h1234; tick(); tick(); flt_valid = 0;
        check("R10 zero count ignored", sig_i, 0);
        // R9: a clear in the middle of a run, with valid high
        obs_count = 20'd50; holdoff = 8'd2; pulse_sync(); run(10);
        flt_valid = 1; sig_clr = 1; tick(); sig_clr = 0; flt_valid = 0;
        check("R9 clear mid-run", sig_i, 0);
        check("R9 done low", done, 0);
        run(5);
        // a long run with the pseudonoise source active
        src_sel = 2'b10; obs_count = 20'd200; holdoff = 8'd1; pulse_sync(); run(400);
        // R1: reset in the middle of a run
        clear(); obs_count = 20'd40; pulse_sync(); run(10);
        rst_n = 0; tick(); rst_n = 1;
        check("R1 mid-run reset", sig_i, 0);
        run(20);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule